// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two component predictors side by side. One is a table of 2-bit saturating counters indexed by the global branch history, the outcomes of the most recent resolved branches. The other is a table of the same counters indexed by bits of the branch address. A third table, also indexed by the branch address, holds 2-bit chooser counters that decide which component supplies the final answer for that address.

The fetch stage presents the address index bits of a branch on the lookup port. It receives, in the same cycle, the final direction, which component was chosen, and both component opinions. It keeps those opinions with the branch. When the branch resolves, the back end returns the index, the real outcome and the two remembered opinions on the update port. The block then trains both component counters with the outcome. It nudges the chooser toward whichever component was right, and shifts the outcome into the history register. One lookup and one update may occur in every cycle. The lookup path is purely combinational, so a lookup always sees the table contents as they stood before the clock edge that applies a concurrent update.

The index width `HIST_W` sets the history length and the number of address bits, so all three tables have 2^HIST_W entries.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter in all three tables holds 1 and the history register is 0. Every lookup therefore returns lk_taken=0, lk_use_local=0, lk_glob_pred=0 and lk_loc_pred=0, and ghist reads 0.
- R2: lk_use_local is the MSB of the chooser counter at lk_pc_idx (1 = local component chosen). lk_glob_pred and lk_loc_pred are the MSBs of the respective component counters (1 = taken). lk_taken equals lk_loc_pred when lk_use_local is 1 and lk_glob_pred otherwise.
- R3: On every update, both the global entry and the local entry are trained with up_taken. Each counter goes up by one on taken and down by one on not taken, holding at 3 and at 0.
- R4: On every update the history register shifts left by one and takes up_taken into bit 0, so the newest outcome sits at the LSB.
- R5: The chooser entry at up_pc_idx moves up by one (toward local, holding at 3) when up_loc_pred matched up_taken and up_glob_pred did not. It moves down by one (toward global, holding at 0) in the opposite case. It is left unchanged when both opinions were right or both were wrong.
- R6: A chooser entry that prefers one component switches to the other only after two consecutive updates in which only the other component was right, starting from a strong state (0 or 3).
- R7: The global table is read and written at the index given by the current history register. The local and chooser tables are read at lk_pc_idx and written at up_pc_idx, so different addresses with the same history share the global entry.
- R8: When a lookup and an update address the same entries in one cycle, the lookup returns the values held before that update; the new values are visible from the next cycle.
- R9: While up_valid is 0, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc_idx | input | HIST_W | Index bits of the branch address being looked up |
| lk_taken | output | 1 | Final predicted direction, 1 = taken |
| lk_use_local | output | 1 | 1 when the local component was chosen |
| lk_glob_pred | output | 1 | Opinion of the history-indexed component |
| lk_loc_pred | output | 1 | Opinion of the address-indexed component |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc_idx | input | HIST_W | Index bits of the resolved branch address |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_glob_pred | input | 1 | Global opinion returned at lookup time |
| up_loc_pred | input | 1 | Local opinion returned at lookup time |
| ghist | output | HIST_W | Current global history register |

## Verification
The bench builds the block with HIST_W set to 4, so each table has sixteen entries and a complete sweep of every address index after each scenario costs only a few dozen cycles. With four history bits, the global index wraps through all sixteen values within a short outcome stream. Global entries are therefore revisited and driven to both saturation limits, and different addresses under one history can be seen sharing a global entry. The small width also lets the chooser be steered through every state of one entry with opinions supplied directly on the update port.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_RESET = 2'b01;

  typedef enum logic [1:0] {
    SEL_HOLD      = 2'd0,
    SEL_TO_LOCAL  = 2'd1,
    SEL_TO_GLOBAL = 2'd2
  } sel_step_e;

  // Saturating two-bit train step: up on taken, down on not taken.
  function automatic ctr2_t ctr_train(input ctr2_t c, input logic taken);
    ctr2_t n;
    if (taken) n = (c == 2'b11) ? c : ctr2_t'(c + 2'b01);
    else       n = (c == 2'b00) ? c : ctr2_t'(c - 2'b01);
    return n;
  endfunction

  // Direction of a counter: upper half means taken / prefer local.
  function automatic logic ctr_dir(input ctr2_t c);
    return c[1];
  endfunction

  // Which way the chooser goes, given correctness of each component.
  function automatic sel_step_e sel_judge(input logic glob_ok, input logic loc_ok);
    sel_step_e s;
    if (loc_ok && !glob_ok)      s = SEL_TO_LOCAL;
    else if (glob_ok && !loc_ok) s = SEL_TO_GLOBAL;
    else                         s = SEL_HOLD;
    return s;
  endfunction

  function automatic ctr2_t sel_apply(input ctr2_t c, input sel_step_e s);
    ctr2_t n;
    case (s)
      SEL_TO_LOCAL:  n = ctr_train(c, 1'b1);
      SEL_TO_GLOBAL: n = ctr_train(c, 1'b0);
      default:       n = c;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t cells [DEPTH];

  assign rd_ctr = cells[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_RESET;
    end else if (wr_en) begin
      cells[wr_idx] <= ctr_train(cells[wr_idx], wr_taken);
    end
  end

endmodule

// File: rtl/tbp_sel_table.sv
module tbp_sel_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             glob_ok,
  input  logic             loc_ok,
  output logic             to_local,
  output logic             to_global
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t     cells [DEPTH];
  sel_step_e step;

  assign step      = sel_judge(glob_ok, loc_ok);
  assign to_local  = wr_en && (step == SEL_TO_LOCAL);
  assign to_global = wr_en && (step == SEL_TO_GLOBAL);
  assign rd_ctr    = cells[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_RESET;
    end else if (wr_en) begin
      cells[wr_idx] <= sel_apply(cells[wr_idx], step);
    end
  end

endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] lk_pc_idx,
  output logic              lk_taken,
  output logic              lk_use_local,
  output logic              lk_glob_pred,
  output logic              lk_loc_pred,
  input  logic              up_valid,
  input  logic [HIST_W-1:0] up_pc_idx,
  input  logic              up_taken,
  input  logic              up_glob_pred,
  input  logic              up_loc_pred,
  output logic [HIST_W-1:0] ghist
);

  ctr2_t glob_rd, loc_rd, sel_rd;
  logic  glob_ok, loc_ok;
  logic  sel_to_local, sel_to_global;
  logic  upd_fire;

  assign upd_fire = up_valid;
  assign glob_ok  = (up_glob_pred == up_taken);
  assign loc_ok   = (up_loc_pred == up_taken);

  tbp_ghr #(.HIST_W(HIST_W)) i_ghr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_fire),
    .bit_in   (up_taken),
    .hist     (ghist)
  );

  // Global table: read and written at the current history.
  tbp_ctr_table #(.IDX_W(HIST_W)) i_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (ghist),
    .rd_ctr   (glob_rd),
    .wr_en    (upd_fire),
    .wr_idx   (ghist),
    .wr_taken (up_taken)
  );

  // Local table: indexed by branch address bits.
  tbp_ctr_table #(.IDX_W(HIST_W)) i_loc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_pc_idx),
    .rd_ctr   (loc_rd),
    .wr_en    (upd_fire),
    .wr_idx   (up_pc_idx),
    .wr_taken (up_taken)
  );

  tbp_sel_table #(.IDX_W(HIST_W)) i_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (lk_pc_idx),
    .rd_ctr    (sel_rd),
    .wr_en     (upd_fire),
    .wr_idx    (up_pc_idx),
    .glob_ok   (glob_ok),
    .loc_ok    (loc_ok),
    .to_local  (sel_to_local),
    .to_global (sel_to_global)
  );

  assign lk_glob_pred = ctr_dir(glob_rd);
  assign lk_loc_pred  = ctr_dir(loc_rd);
  assign lk_use_local = ctr_dir(sel_rd);
  assign lk_taken     = lk_use_local ? lk_loc_pred : lk_glob_pred;

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic              up_glob_pred,
  input logic              up_loc_pred,
  input logic [HIST_W-1:0] ghist,
  input logic              sel_to_local,
  input logic              sel_to_global
);

  // R4: newest outcome enters at the LSB
  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist == {$past(ghist[HIST_W-2:0]), $past(up_taken)});

  // R9: history frozen without an update
  p_hist_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));

  // R1: history cleared coming out of reset
  p_hist_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ghist == '0);

  // R5: chooser moves toward local only when local alone was right
  p_to_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_to_local |-> (up_loc_pred == up_taken) && (up_glob_pred != up_taken));

  // R5: chooser moves toward global only when global alone was right
  p_to_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_to_global |-> (up_glob_pred == up_taken) && (up_loc_pred != up_taken));

  // R6: at most one direction of chooser movement per update
  p_one_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_to_local, sel_to_global}));

  // R9: chooser never moves without an update
  p_move_needs_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_to_local || sel_to_global) |-> up_valid);

endmodule

bind tourney_bp tbp_checker #(.HIST_W(HIST_W)) i_tbp_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .up_valid      (up_valid),
  .up_taken      (up_taken),
  .up_glob_pred  (up_glob_pred),
  .up_loc_pred   (up_loc_pred),
  .ghist         (ghist),
  .sel_to_local  (sel_to_local),
  .sel_to_global (sel_to_global)
);

// File: tb/test_tourney_bp.sv
`timescale 1ns/1ps
module test_tourney_bp;

  localparam int HW = 4;
  localparam int N  = 1 << HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] lk_pc_idx = '0;
  logic          lk_taken, lk_use_local, lk_glob_pred, lk_loc_pred;
  logic          up_valid = 1'b0;
  logic [HW-1:0] up_pc_idx = '0;
  logic          up_taken = 1'b0;
  logic          up_glob_pred = 1'b0;
  logic          up_loc_pred = 1'b0;
  logic [HW-1:0] ghist;

  tourney_bp #(.HIST_W(HW)) i_tourney_bp (
    .clk(clk), .rst_n(rst_n), .lk_pc_idx(lk_pc_idx),
    .lk_taken(lk_taken), .lk_use_local(lk_use_local),
    .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
    .up_valid(up_valid), .up_pc_idx(up_pc_idx), .up_taken(up_taken),
    .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred), .ghist(ghist)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit reported = 0;

  // Reference state kept as plain integers.
  int mg [N];
  int ml [N];
  int ms [N];
  int mh;

  // Captured lookup results.
  int r_taken, r_use, r_g, r_l;

  function automatic int bump(int v, bit up);
    if (up) return (v >= 3) ? 3 : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  function automatic int chooser(int v, bit g_right, bit l_right);
    if (g_right == l_right) return v;
    return bump(v, l_right);
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      mg[i] = 1; ml[i] = 1; ms[i] = 1;
    end
    mh = 0;
  endtask

  task automatic look(int idx);
    @(negedge clk);
    lk_pc_idx = idx[HW-1:0];
    #1;
    r_taken = int'(lk_taken);
    r_use   = int'(lk_use_local);
    r_g     = int'(lk_glob_pred);
    r_l     = int'(lk_loc_pred);
  endtask

  task automatic upd(int idx, bit t, bit gp, bit lp);
    @(negedge clk);
    up_valid = 1'b1;
    up_pc_idx = idx[HW-1:0];
    up_taken = t; up_glob_pred = gp; up_loc_pred = lp;
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    mg[mh]  = bump(mg[mh], t);
    ml[idx] = bump(ml[idx], t);
    ms[idx] = chooser(ms[idx], gp == t, lp == t);
    mh = ((mh << 1) | int'(t)) & (N - 1);
  endtask

  task automatic step(int idx, bit t);
    look(idx);
    upd(idx, t, r_g[0], r_l[0]);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) begin
      int eg, el, es;
      look(i);
      eg = mg[mh] / 2; el = ml[i] / 2; es = ms[i] / 2;
      chk({tag, " R7 global opinion at history"}, r_g, eg);
      chk({tag, " R7 local opinion at index"}, r_l, el);
      chk({tag, " R2 chooser bit"}, r_use, es);
      chk({tag, " R2 final direction"}, r_taken, es ? el : eg);
    end
    chk({tag, " R4 history"}, int'(ghist), mh);
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin
      look(i);
      chk("R1 taken after reset", r_taken, 0);
      chk("R1 use_local after reset", r_use, 0);
      chk("R1 glob after reset", r_g, 0);
      chk("R1 loc after reset", r_l, 0);
    end
    chk("R1 history after reset", int'(ghist), 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 5; k++) begin
      step(5, 1'b1);
      look(5);
      chk("R3 local up, saturating at 3", r_l, ml[5] / 2);
    end
    chk("R3 local stays taken after 5 takens", r_l, 1);
    for (int k = 0; k < 5; k++) begin
      step(5, 1'b0);
      look(5);
      chk("R3 local down, saturating at 0", r_l, ml[5] / 2);
    end
    chk("R3 local not taken after 5 not-takens", r_l, 0);
    step(5, 1'b1);
    look(5);
    chk("R3 one taken from 0 stays not taken", r_l, 0);
    check_all("saturate");
  endtask

  task automatic t_history();
    bit pat [6] = '{1, 0, 1, 1, 0, 1};
    for (int k = 0; k < 6; k++) begin
      step(3, pat[k]);
      chk("R4 history shift", int'(ghist), mh);
    end
    chk("R4 history pattern", int'(ghist), 4'b1101);
    // Two addresses under one history read the same global entry.
    look(0);
    chk("R7 global shared idx0", r_g, mg[mh] / 2);
    look(15);
    chk("R7 global shared idx15", r_g, mg[mh] / 2);
    check_all("history");
  endtask

  task automatic t_selector();
    look(9); chk("R1 chooser idx9 starts global", r_use, 0);
    upd(9, 1, 0, 1); look(9); chk("R5 local alone right moves to local", r_use, 1);
    upd(9, 1, 0, 1); look(9); chk("R5 strong local", r_use, 1);
    upd(9, 1, 1, 0); look(9); chk("R6 one miss keeps local", r_use, 1);
    upd(9, 1, 1, 0); look(9); chk("R6 second miss flips to global", r_use, 0);
    upd(9, 1, 0, 0); upd(9, 1, 0, 0);
    look(9); chk("R5 both wrong holds", r_use, 0);
    upd(9, 1, 0, 1); look(9); chk("R5 hold left state at 1", r_use, 1);
    upd(9, 1, 1, 0); look(9); chk("R5 back to weak global", r_use, 0);
    upd(9, 1, 1, 1); upd(9, 1, 1, 1);
    upd(9, 1, 1, 0); look(9); chk("R5 both right held state at 1", r_use, 0);
    upd(9, 1, 0, 1); look(9); chk("R6 strong global needs two", r_use, 0);
    upd(9, 1, 0, 1); look(9); chk("R6 second local win flips", r_use, 1);
    chk("R5 chooser model agrees", r_use, ms[9] / 2);
    check_all("selector");
  endtask

  task automatic t_same_cycle();
    int pre_l, pre_u;
    look(12);
    pre_l = r_l; pre_u = r_use;
    @(negedge clk);
    lk_pc_idx = 4'd12;
    up_valid = 1'b1; up_pc_idx = 4'd12; up_taken = 1'b1;
    up_glob_pred = 1'b0; up_loc_pred = 1'b1;
    #1;
    chk("R8 same-cycle local is pre-update", int'(lk_loc_pred), pre_l);
    chk("R8 same-cycle chooser is pre-update", int'(lk_use_local), pre_u);
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    mg[mh] = bump(mg[mh], 1);
    ml[12] = bump(ml[12], 1);
    ms[12] = chooser(ms[12], 0, 1);
    mh = ((mh << 1) | 1) & (N - 1);
    look(12);
    chk("R8 update visible next cycle (local)", r_l, ml[12] / 2);
    chk("R8 update visible next cycle (chooser)", r_use, ms[12] / 2);
    check_all("same_cycle");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      up_valid = 1'b0;
      up_pc_idx = k[HW-1:0];
      up_taken = k[0];
      up_glob_pred = ~k[0];
      up_loc_pred = k[0];
    end
    @(negedge clk);
    chk("R9 history unchanged when idle", int'(ghist), mh);
    check_all("R9 idle");
  endtask

  task automatic t_mixed();
    logic [7:0] lfsr = 8'hA5;
    for (int k = 0; k < 320; k++) begin
      bit t;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      t = (lfsr[2:0] != 3'd0) ^ lfsr[7];
      step(int'(lfsr[3:0] & 4'hB), t);
      if ((k % 80) == 79) check_all("mixed");
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_saturate();
    t_history();
    t_selector();
    t_same_cycle();
    t_idle();
    t_mixed();
    check_all("final");
    report();
  end

endmodule